// File: doc/BRIEF.md
# Banked and Indirect Data Address Mapper

This block sits between an 8-bit CPU core and its data-side storage. It turns each data access into a select strobe for one storage target, plus a local address inside that target. A direct access takes its bank number from a 5-bit bank register and its offset from the 7-bit field in the instruction. An indirect access takes both from a 16-bit pointer. If the top bit of that pointer is set, the access goes to program memory instead. In that case the low bits of the pointer are the word address, and the low byte of the word is the result.

Each 128-byte bank is split by offset into four regions:
- core registers at 0x00–0x0B,
- special registers at 0x0C–0x1F,
- general RAM from 0x20 up,
- common RAM at 0x70–0x7F.

Core registers and common RAM are one physical store seen from every bank. Locations that no target implements read as zero and take no writes. A program-memory read holds the core for exactly one wait cycle. A program-memory write is dropped.

The access request uses a valid/ready handshake. The core raises `acc_valid` with the access fields. It must hold every request field stable while `acc_ready` is low. The access completes in the cycle where `acc_valid` and `acc_ready` are both high. The block applies back-pressure (`acc_ready` low) only during the program-memory wait cycle. All targets return their read byte on one shared input bus, `ret_byte`. Data targets drive it in the cycle of their strobe. Program memory drives it in the cycle after its strobe.

Top module: `dam_mapper`

## Requirements
- R1: A direct access with offset 0x00–0x0B raises `sel_core` with `loc_addr` equal to the offset, whatever the bank.
- R2: An offset 0x0C–0x1F raises `sel_sfr` with `loc_addr` = bank*20 + (offset-12).
- R3: An offset from 0x20 up to 0x20+GPR_BYTES-1, in a bank below GPR_BANKS, raises `sel_gpr` with `loc_addr` = bank*GPR_BYTES + (offset-0x20). The same offset in any higher bank is unimplemented.
- R4: An offset 0x70–0x7F raises `sel_com` with `loc_addr` = offset-0x70, whatever the bank.
- R5: An indirect access with pointer bit 15 clear uses pointer bits 11:7 as the bank and bits 6:0 as the offset. A nonzero value in pointer bits 14:12 makes the access unimplemented.
- R6: An unimplemented access raises no strobe and no `wr_en`, and drives `loc_addr` to 0. A read of it completes with `rd_data` = 0. At most one strobe is high in any cycle.
- R7: An indirect read with pointer bit 15 set raises `stall` and `sel_pm` and drops `acc_ready` in its first cycle. `pm_addr` equals the pointer modulo 2**PM_AW. The stall never lasts more than one cycle.
- R8: In the cycle after the stall, `stall` is low, `acc_ready` is high, and `rd_valid` is high with `rd_data` = `ret_byte`. Back-to-back program-memory reads each take one stall cycle.
- R9: An indirect write with pointer bit 15 set raises no strobe, no `wr_en` and no stall, and completes at once.
- R10: A data-target read completes in its own cycle with `rd_valid` high and `rd_data` = `ret_byte`. A write raises `wr_en` with the strobe and leaves `rd_valid` low.
- R11: After reset with no request, `stall`, every strobe, `wr_en` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_indirect | input | 1 | 1 = pointer access, 0 = direct access |
| acc_write | input | 1 | 1 = write, 0 = read |
| bank_sel | input | 5 | Active bank for direct accesses |
| acc_offset | input | 7 | Offset field of a direct access |
| fsr_ptr | input | 16 | Pointer for indirect accesses |
| ret_byte | input | 8 | Read byte returned by the selected target |
| sel_core | output | 1 | Core register strobe |
| sel_sfr | output | 1 | Special register strobe |
| sel_gpr | output | 1 | General RAM strobe |
| sel_com | output | 1 | Common RAM strobe |
| sel_pm | output | 1 | Program memory read strobe |
| wr_en | output | 1 | Write enable for the strobed data target |
| loc_addr | output | 12 | Local address inside the strobed data target |
| pm_addr | output | 13 | Program memory word address |
| stall | output | 1 | Program-memory wait cycle |
| rd_valid | output | 1 | Read completes this cycle |
| rd_data | output | 8 | Read result |

## Verification
The end of one program-memory wait and the start of the next request meet at a single clock edge. Back-to-back pointer reads into program memory provoke this: the bench presents a second read, with a different wrapped address, right in the completion cycle of the first. It then checks that `stall` runs 1,0,1,0 and that each completion delivers its own returned byte. A write through a program-memory pointer is placed next to these reads. The bench checks that it neither stalls nor leaves a stale wait behind.

// File: rtl/dam_pkg.sv
package dam_pkg;
  // Offset boundaries inside one 128-byte bank
  localparam int CORE_N   = 12;   // core registers at 0x00..0x0B
  localparam int SFR_END  = 32;   // special registers up to 0x1F
  localparam int SFR_N    = SFR_END - CORE_N;
  localparam int GPR_BASE = 32;   // general RAM starts at 0x20
  localparam int COM_BASE = 112;  // common RAM at 0x70..0x7F

  typedef enum logic [2:0] {
    RG_HOLE, RG_CORE, RG_SFR, RG_GPR, RG_COM, RG_PM
  } region_t;
endpackage

// File: rtl/dam_decode.sv
module dam_decode
  import dam_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int OFF_W     = 7,
  parameter int PTR_W     = 16,
  parameter int PM_AW     = 13,
  parameter int LA_W      = 12,
  parameter int GPR_BYTES = 80,
  parameter int GPR_BANKS = 8
) (
  input  logic              indirect,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PTR_W-1:0]  ptr,
  output region_t           region,
  output logic [LA_W-1:0]   loc_addr,
  output logic [PM_AW-1:0]  pm_addr
);
  localparam int HI_LSB  = BANK_W + OFF_W;
  localparam int HI_W    = PTR_W - 1 - HI_LSB;
  localparam int GPR_END = GPR_BASE + GPR_BYTES;

  logic [BANK_W-1:0] eff_bank;
  logic [OFF_W-1:0]  eff_off;
  logic              hi_bad;
  logic              to_pm;

  assign to_pm    = indirect & ptr[PTR_W-1];
  assign eff_bank = indirect ? ptr[HI_LSB-1:OFF_W] : bank;
  assign eff_off  = indirect ? ptr[OFF_W-1:0]      : offset;
  assign hi_bad   = indirect & (ptr[PTR_W-2:HI_LSB] != '0);
  assign pm_addr  = ptr[PM_AW-1:0];

  always_comb begin
    region = RG_HOLE;
    if (to_pm)                                region = RG_PM;
    else if (hi_bad)                          region = RG_HOLE;
    else if (int'(eff_off) < CORE_N)          region = RG_CORE;
    else if (int'(eff_off) < SFR_END)         region = RG_SFR;
    else if (int'(eff_off) >= COM_BASE)       region = RG_COM;
    else if (int'(eff_off) < GPR_END && int'(eff_bank) < GPR_BANKS)
                                              region = RG_GPR;
  end

  always_comb begin
    unique case (region)
      RG_CORE: loc_addr = LA_W'(eff_off);
      RG_SFR:  loc_addr = LA_W'(eff_bank) * LA_W'(SFR_N)
                        + (LA_W'(eff_off) - LA_W'(CORE_N));
      RG_GPR:  loc_addr = LA_W'(eff_bank) * LA_W'(GPR_BYTES)
                        + (LA_W'(eff_off) - LA_W'(GPR_BASE));
      RG_COM:  loc_addr = LA_W'(eff_off) - LA_W'(COM_BASE);
      default: loc_addr = '0;
    endcase
  end
endmodule

// File: rtl/dam_pm_wait.sv
module dam_pm_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic pm_rd,
  output logic stall
);
  logic wait_q;

  assign stall = pm_rd & ~wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= stall;
  end
endmodule

// File: rtl/dam_rdmux.sv
module dam_rdmux #(
  parameter int DW = 8
) (
  input  logic          valid,
  input  logic          ready,
  input  logic          write,
  input  logic          hole,
  input  logic [DW-1:0] ret,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  assign rd_valid = valid & ready & ~write;
  assign rd_data  = (rd_valid & ~hole) ? ret : '0;
endmodule

// File: rtl/dam_mapper.sv
module dam_mapper
  import dam_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int OFF_W     = 7,
  parameter int PTR_W     = 16,
  parameter int PM_AW     = 13,
  parameter int LA_W      = 12,
  parameter int DW        = 8,
  parameter int GPR_BYTES = 80,
  parameter int GPR_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_indirect,
  input  logic              acc_write,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [OFF_W-1:0]  acc_offset,
  input  logic [PTR_W-1:0]  fsr_ptr,
  input  logic [DW-1:0]     ret_byte,
  output logic              sel_core,
  output logic              sel_sfr,
  output logic              sel_gpr,
  output logic              sel_com,
  output logic              sel_pm,
  output logic              wr_en,
  output logic [LA_W-1:0]   loc_addr,
  output logic [PM_AW-1:0]  pm_addr,
  output logic              stall,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  region_t region;
  logic    data_hit;
  logic    pm_rd;

  dam_decode #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .PTR_W(PTR_W), .PM_AW(PM_AW),
    .LA_W(LA_W), .GPR_BYTES(GPR_BYTES), .GPR_BANKS(GPR_BANKS)
  ) dec_i (
    .indirect (acc_indirect),
    .bank     (bank_sel),
    .offset   (acc_offset),
    .ptr      (fsr_ptr),
    .region   (region),
    .loc_addr (loc_addr),
    .pm_addr  (pm_addr)
  );

  assign pm_rd = acc_valid & (region == RG_PM) & ~acc_write;

  dam_pm_wait wait_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pm_rd (pm_rd),
    .stall (stall)
  );

  assign acc_ready = ~stall;
  assign data_hit  = (region != RG_HOLE) & (region != RG_PM);

  assign sel_core = acc_valid & (region == RG_CORE);
  assign sel_sfr  = acc_valid & (region == RG_SFR);
  assign sel_gpr  = acc_valid & (region == RG_GPR);
  assign sel_com  = acc_valid & (region == RG_COM);
  assign sel_pm   = stall;
  assign wr_en    = acc_valid & acc_write & data_hit;

  dam_rdmux #(.DW(DW)) rd_i (
    .valid    (acc_valid),
    .ready    (acc_ready),
    .write    (acc_write),
    .hole     (region == RG_HOLE),
    .ret      (ret_byte),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/dam_mapper_chk.sv
module dam_mapper_chk #(
  parameter int LA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_ready,
  input logic            acc_indirect,
  input logic            acc_write,
  input logic [6:0]      acc_offset,
  input logic            fsr_top,
  input logic            sel_core,
  input logic            sel_sfr,
  input logic            sel_gpr,
  input logic            sel_com,
  input logic            sel_pm,
  input logic            wr_en,
  input logic [LA_W-1:0] loc_addr,
  input logic            stall,
  input logic            rd_valid
);
  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R7
  stall_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel_pm && !acc_ready));

  // R8
  pm_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!acc_valid || !acc_indirect || !fsr_top || acc_write || rd_valid));

  // R6
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_core, sel_sfr, sel_gpr, sel_com, sel_pm}));

  // R9
  pm_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_indirect && acc_write && fsr_top) |-> (!stall && acc_ready && !wr_en));

  // R1
  core_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_indirect && acc_offset < 7'd12) |-> (sel_core && loc_addr == LA_W'(acc_offset)));

  // R10
  write_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_valid);
endmodule

bind dam_mapper dam_mapper_chk #(.LA_W(LA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_indirect(acc_indirect), .acc_write(acc_write),
  .acc_offset(acc_offset[6:0]), .fsr_top(fsr_ptr[PTR_W-1]),
  .sel_core(sel_core), .sel_sfr(sel_sfr), .sel_gpr(sel_gpr),
  .sel_com(sel_com), .sel_pm(sel_pm), .wr_en(wr_en),
  .loc_addr(loc_addr), .stall(stall), .rd_valid(rd_valid)
);

// File: tb/dam_mapper_tb_top.sv
module dam_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_indirect = 1'b0, acc_write = 1'b0;
  logic        acc_ready;
  logic [4:0]  bank_sel = '0;
  logic [6:0]  acc_offset = '0;
  logic [15:0] fsr_ptr = '0;
  logic [7:0]  ret_byte = 8'hA5;
  logic        sel_core, sel_sfr, sel_gpr, sel_com, sel_pm, wr_en;
  logic [11:0] loc_addr;
  logic [12:0] pm_addr;
  logic        stall, rd_valid;
  logic [7:0]  rd_data;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  dam_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_indirect(acc_indirect), .acc_write(acc_write), .bank_sel(bank_sel),
    .acc_offset(acc_offset), .fsr_ptr(fsr_ptr), .ret_byte(ret_byte),
    .sel_core(sel_core), .sel_sfr(sel_sfr), .sel_gpr(sel_gpr),
    .sel_com(sel_com), .sel_pm(sel_pm), .wr_en(wr_en), .loc_addr(loc_addr),
    .pm_addr(pm_addr), .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fields: ind, wr, bank, off, ptr, sel{core,sfr,gpr,com,pm}, loc, we, req
  localparam int NV = 14;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0,1'b0,5'd3, 7'h05,16'h0000,5'b10000,12'd5,  1'b0,4'd1},  // R1
    {1'b0,1'b0,5'd17,7'h0B,16'h0000,5'b10000,12'd11, 1'b0,4'd1},  // R1
    {1'b0,1'b0,5'd2, 7'h0C,16'h0000,5'b01000,12'd40, 1'b0,4'd2},  // R2
    {1'b0,1'b0,5'd31,7'h1F,16'h0000,5'b01000,12'd639,1'b0,4'd2},  // R2
    {1'b0,1'b0,5'd1, 7'h20,16'h0000,5'b00100,12'd80, 1'b0,4'd3},  // R3
    {1'b0,1'b0,5'd7, 7'h6F,16'h0000,5'b00100,12'd639,1'b0,4'd3},  // R3
    {1'b0,1'b0,5'd8, 7'h30,16'h0000,5'b00000,12'd0,  1'b0,4'd6},  // R6 hole bank
    {1'b0,1'b0,5'd9, 7'h7F,16'h0000,5'b00010,12'd15, 1'b0,4'd4},  // R4
    {1'b0,1'b0,5'd0, 7'h70,16'h0000,5'b00010,12'd0,  1'b0,4'd4},  // R4
    {1'b1,1'b0,5'd0, 7'h00,16'h0225,5'b00100,12'd325,1'b0,4'd5},  // R5
    {1'b1,1'b0,5'd0, 7'h00,16'h1003,5'b00000,12'd0,  1'b0,4'd5},  // R5 hole
    {1'b1,1'b0,5'd0, 7'h00,16'h0F82,5'b10000,12'd2,  1'b0,4'd5},  // R5
    {1'b0,1'b1,5'd5, 7'h40,16'h0000,5'b00100,12'd432,1'b1,4'd10}, // R10
    {1'b0,1'b1,5'd10,7'h40,16'h0000,5'b00000,12'd0,  1'b0,4'd6}   // R6 hole write
  };

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    check("R11 stall", stall, 0);
    check("R11 strobes", {sel_core,sel_sfr,sel_gpr,sel_com,sel_pm,wr_en}, 0);
    check("R11 rd_valid", rd_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string t;
      v = VEC[i];
      @(negedge clk);
      acc_valid = 1'b1;
      acc_indirect = v[51]; acc_write = v[50]; bank_sel = v[49:45];
      acc_offset = v[44:38]; fsr_ptr = v[37:22];
      #1;
      t = $sformatf("R%0d vec%0d", v[3:0], i);
      check({t," sel"}, {sel_core,sel_sfr,sel_gpr,sel_com,sel_pm}, v[21:17]);
      check({t," loc"}, loc_addr, v[16:5]);
      check({t," we"}, wr_en, v[4]);
      check({t," rd_valid"}, rd_valid, !v[50]);
      check({t," rd_data"}, rd_data, (v[21:17] != 0 && !v[50]) ? 8'hA5 : 8'h00);
      check({t," ready"}, acc_ready, 1);
    end

    // R7 / R8 back-to-back program memory reads
    @(negedge clk);
    acc_indirect = 1'b1; acc_write = 1'b0; fsr_ptr = 16'hA345; ret_byte = 8'hC7;
    #1;
    check("R7 stall first", stall, 1);
    check("R7 sel_pm", sel_pm, 1);
    check("R7 ready low", acc_ready, 0);
    check("R7 wrap addr", pm_addr, 13'h0345);
    check("R7 no rd_valid", rd_valid, 0);
    @(negedge clk); #1;
    check("R8 stall clear", stall, 0);
    check("R8 ready", acc_ready, 1);
    check("R8 rd_valid", rd_valid, 1);
    check("R8 rd_data", rd_data, 8'hC7);
    check("R8 no sel_pm", sel_pm, 0);
    @(negedge clk);
    fsr_ptr = 16'hFFFF; ret_byte = 8'h3C;
    #1;
    check("R8 second stall", stall, 1);
    check("R7 wrap addr 2", pm_addr, 13'h1FFF);
    @(negedge clk); #1;
    check("R8 second done", {stall, rd_valid}, 2'b01);
    check("R8 second data", rd_data, 8'h3C);

    // R9 write through program memory pointer
    @(negedge clk);
    acc_write = 1'b1; fsr_ptr = 16'h8010;
    #1;
    check("R9 no stall", stall, 0);
    check("R9 ready", acc_ready, 1);
    check("R9 strobes", {sel_core,sel_sfr,sel_gpr,sel_com,sel_pm,wr_en}, 0);
    @(negedge clk); #1;
    check("R9 still no stall", stall, 0);

    // R11 idle after traffic
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    #1;
    check("R11 idle strobes", {sel_core,sel_sfr,sel_gpr,sel_com,sel_pm,wr_en,stall}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule